// File: doc/BRIEF.md
# Card Bus Byte-Lane Steering Decoder

This block sits on the card side of a 16-bit card bus and decides, for every host cycle, which bytes of a small internal register file are read or written and on which half of the data bus they travel. The host drives two active-low card enables, an address (bit 0 picks the byte within a word), a space-select line and one of four strobes: memory read, memory write, I/O read and I/O write. An 8-bit host can reach every byte on the low lane because the odd byte can be steered there. A 16-bit host gets whole words on both lanes.

Two register spaces are decoded. The task file is a 16-offset window, with aliases for the data, feature and reserved offsets. It is reached by I/O cycles and by common-memory cycles, and it repeats every 16 bytes of the common window. The attribute space holds four 8-bit configuration registers at even addresses starting at 200h. The block also flags when a 16-bit data port is addressed and acknowledges I/O reads it answers. All strobes are assumed to be synchronous to `clk`.

A four-state controller sequences each cycle. Its states are IDLE, READ, WRITE and COMMIT. The transitions are:
- IDLE→READ when a read strobe falls.
- IDLE→WRITE when a write strobe falls and no read strobe is low.
- READ→IDLE when the read strobes are released.
- WRITE→COMMIT when the write strobe rises.
- COMMIT→IDLE unconditionally.

Top module: `cbd_decoder`

## Requirements
- R1: When `ce2_n` is low, the odd byte of the addressed word (byte address bit 0 = 1) travels on `wdata[15:8]`/`rdata[15:8]`, and `lane_en[1]` is high during the read.
- R2: When only `ce1_n` is low, the byte selected by `addr[0]` travels on the low lane (`lane_en` = 01). When both enables are low, the even byte is on the low lane and the odd byte is on the high lane (`lane_en` = 11), whatever `addr[0]` is.
- R3: In a memory cycle, `reg_n` = 0 selects attribute space and `reg_n` = 1 selects the task file, mirrored every 16 bytes. An I/O cycle reaches the task file only with `reg_n` = 0. With `reg_n` = 1 it selects nothing: `lane_en` = 00, `rdata` = 0000h, and writes are ignored.
- R4: A write takes effect one clock after the write strobe returns high. It uses the address, enables and data present in the last cycle the strobe was low, so later bus changes have no effect on it.
- R5: With both enables high, no byte is read or written and `lane_en` stays 00.
- R6: `is16_n` is low exactly while an I/O strobe is low, `reg_n` = 0, at least one enable is low and `addr[2:0]` = 0 (task-file offsets 0 and 8). Otherwise it is high.
- R7: `inpack_n` is low only in the READ state of an I/O read that selects at least one lane. It stays high for memory reads.
- R8: Attribute byte addresses 200h, 202h, 204h and 206h hold four read/write configuration registers. Every other attribute address reads 00h and ignores writes, including all odd addresses.
- R9: Task-file offsets 0 and 8 share the data low byte. Offset 9 is the data high byte, which is also the odd byte of a word access at offset 0. Offsets 1 and 0Dh share the feature byte, so a `ce2_n`-only write at offset 0 stores `wdata[15:8]` there. Offsets 0Ah–0Ch read 00h and ignore writes. All other offsets are plain bytes.
- R10: After reset every register holds 00h, `rdata` = 0000h, `lane_en` = 00, and `inpack_n` and `is16_n` are high.
- R11: Read data and `lane_en` are valid from the first clock edge after a read strobe falls until the strobe rises. Outside the READ state they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Card enable for the low lane, active low |
| ce2_n | input | 1 | Card enable for the high (odd) lane, active low |
| addr | input | 11 | Byte address; bit 0 picks the byte in a word |
| reg_n | input | 1 | Space select: low = attribute (memory) or I/O, high = common memory |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| wdata | input | 16 | Write data, two byte lanes |
| rdata | output | 16 | Read data, two byte lanes |
| lane_en | output | 2 | Lanes driven this cycle (bit 0 low lane, bit 1 high lane) |
| is16_n | output | 1 | Low when a 16-bit data port is addressed |
| inpack_n | output | 1 | Low while an I/O read is being answered |

## Verification
The bench walks all eight combinations of the two enables and `addr[0]`, each at two task-file words. For every combination it does a read, then a write with a distinct pattern, then a byte-wise read-back on the low lane. This separates low-lane from high-lane routing and shows whether `addr[0]` is honoured or ignored. Directed cycles use the aliased offsets to tell the word path (data high byte) apart from the odd-byte path (feature byte). Attribute cycles at even, odd and off-base addresses separate the configuration registers from the holes. A write whose data changes while the strobe is low, and whose address changes as the strobe rises, shows which sample the commit uses.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int TF_DEPTH  = 16;
    localparam int TGT_IDX_W = 4;

    typedef enum logic [1:0] {SP_NONE, SP_TASK, SP_ATTR} space_e;
    typedef enum logic [1:0] {TG_NONE, TG_TASK, TG_CFG} tkind_e;
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_COMMIT} state_e;

    typedef struct packed {
        tkind_e                kind;
        logic [TGT_IDX_W-1:0]  idx;
    } tgt_t;
endpackage

// File: rtl/cbd_lane_steer.sv
module cbd_lane_steer (
    input  logic       ce1_n,
    input  logic       ce2_n,
    input  logic       a0,
    output logic [1:0] lane_on,
    output logic [1:0] lane_odd,
    output logic       word
);
    always_comb begin
        lane_on     = {~ce2_n, ~ce1_n};
        word        = ~ce1_n & ~ce2_n;
        // high lane always carries the odd byte
        lane_odd[1] = 1'b1;
        // low lane: even byte in a word access, else the byte picked by A0
        lane_odd[0] = ce2_n ? a0 : 1'b0;
    end
endmodule

// File: rtl/cbd_byte_map.sv
module cbd_byte_map
    import cbd_pkg::*;
#(
    parameter int              ADDR_W   = 11,
    parameter int              CFG_NUM  = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE = 11'h200
) (
    input  space_e            space,
    input  logic [ADDR_W-1:0] ba,
    input  logic              word,
    output tgt_t              tgt
);
    localparam int CFG_W = $clog2(CFG_NUM);
    localparam logic [ADDR_W-CFG_W-2:0] CFG_HI = CFG_BASE[ADDR_W-1:CFG_W+1];

    always_comb begin
        tgt.kind = TG_NONE;
        tgt.idx  = '0;
        unique case (space)
            SP_TASK: begin
                tgt.kind = TG_TASK;
                unique case (ba[3:0])
                    4'h0, 4'h8:       tgt.idx = 4'h0;
                    4'h1:             tgt.idx = word ? 4'h9 : 4'h1;
                    4'hD:             tgt.idx = 4'h1;
                    4'hA, 4'hB, 4'hC: tgt.kind = TG_NONE;
                    default:          tgt.idx = ba[3:0];
                endcase
            end
            SP_ATTR: begin
                if (!ba[0] && ba[ADDR_W-1:CFG_W+1] == CFG_HI) begin
                    tgt.kind = TG_CFG;
                    tgt.idx  = TGT_IDX_W'(ba[CFG_W:1]);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cbd_regs.sv
module cbd_regs
    import cbd_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CFG_NUM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tgt_t [1:0]             tgt,
    input  logic [1:0]             we,
    input  logic [1:0][BYTE_W-1:0] wbyte,
    output logic [1:0][BYTE_W-1:0] rbyte
);
    localparam int CFG_W = $clog2(CFG_NUM);

    logic [BYTE_W-1:0] tf_q  [TF_DEPTH];
    logic [BYTE_W-1:0] cfg_q [CFG_NUM];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TF_DEPTH; i++) tf_q[i] <= '0;
            for (int i = 0; i < CFG_NUM; i++)  cfg_q[i] <= '0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                if (we[l]) begin
                    if (tgt[l].kind == TG_TASK)
                        tf_q[tgt[l].idx] <= wbyte[l];
                    else if (tgt[l].kind == TG_CFG)
                        cfg_q[tgt[l].idx[CFG_W-1:0]] <= wbyte[l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < 2; l++) begin
            unique case (tgt[l].kind)
                TG_TASK: rbyte[l] = tf_q[tgt[l].idx];
                TG_CFG:  rbyte[l] = cfg_q[tgt[l].idx[CFG_W-1:0]];
                default: rbyte[l] = '0;
            endcase
        end
    end
endmodule

// File: rtl/cbd_decoder.sv
module cbd_decoder
    import cbd_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter int                DATA_W   = 16,
    parameter int                CFG_NUM  = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE = 11'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        lane_en,
    output logic              is16_n,
    output logic              inpack_n
);
    localparam int BYTE_W = DATA_W / 2;

    state_e state_q, state_d;

    logic rd_any, wr_any, io_live, in_commit;
    assign rd_any  = !oe_n || !iord_n;
    assign wr_any  = !we_n || !iowr_n;
    assign io_live = !iord_n || !iowr_n;
    assign in_commit = (state_q == S_COMMIT);

    // captured write cycle
    logic              lat_ce1_n, lat_ce2_n, lat_reg_n, lat_io;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (rd_any) state_d = S_READ;
                      else if (wr_any) state_d = S_WRITE;
            S_READ:   if (!rd_any) state_d = S_IDLE;
            S_WRITE:  if (!wr_any) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_ce1_n <= 1'b1;
            lat_ce2_n <= 1'b1;
            lat_reg_n <= 1'b1;
            lat_io    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (state_d == S_WRITE) begin
            lat_ce1_n <= ce1_n;
            lat_ce2_n <= ce2_n;
            lat_reg_n <= reg_n;
            lat_io    <= !iowr_n;
            lat_addr  <= addr;
            lat_wdata <= wdata;
        end
    end

    // decode source: captured cycle during commit, live bus otherwise
    logic              src_ce1_n, src_ce2_n, src_reg_n, src_io;
    logic [ADDR_W-1:0] src_addr;
    logic [DATA_W-1:0] src_wdata;
    space_e            space;

    always_comb begin
        src_ce1_n = in_commit ? lat_ce1_n : ce1_n;
        src_ce2_n = in_commit ? lat_ce2_n : ce2_n;
        src_reg_n = in_commit ? lat_reg_n : reg_n;
        src_io    = in_commit ? lat_io    : io_live;
        src_addr  = in_commit ? lat_addr  : addr;
        src_wdata = in_commit ? lat_wdata : wdata;
        if (src_io) space = src_reg_n ? SP_NONE : SP_TASK;
        else        space = src_reg_n ? SP_TASK : SP_ATTR;
    end

    logic [1:0] lane_on, lane_odd, live_en, we_lane;
    logic       word;

    cbd_lane_steer u_steer (
        .ce1_n    (src_ce1_n),
        .ce2_n    (src_ce2_n),
        .a0       (src_addr[0]),
        .lane_on  (lane_on),
        .lane_odd (lane_odd),
        .word     (word)
    );

    tgt_t [1:0]             tgt;
    logic [1:0][BYTE_W-1:0] wbyte, rbyte;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        cbd_byte_map #(
            .ADDR_W   (ADDR_W),
            .CFG_NUM  (CFG_NUM),
            .CFG_BASE (CFG_BASE)
        ) u_map (
            .space (space),
            .ba    ({src_addr[ADDR_W-1:1], lane_odd[l]}),
            .word  (word),
            .tgt   (tgt[l])
        );
        assign live_en[l] = lane_on[l] && (space != SP_NONE);
        assign we_lane[l] = in_commit && live_en[l];
        assign wbyte[l]   = src_wdata[l*BYTE_W +: BYTE_W];
    end

    cbd_regs #(
        .BYTE_W  (BYTE_W),
        .CFG_NUM (CFG_NUM)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .tgt   (tgt),
        .we    (we_lane),
        .wbyte (wbyte),
        .rbyte (rbyte)
    );

    // output process
    always_comb begin
        rdata    = '0;
        lane_en  = '0;
        inpack_n = 1'b1;
        unique case (state_q)
            S_READ: begin
                lane_en = live_en;
                for (int l = 0; l < 2; l++)
                    rdata[l*BYTE_W +: BYTE_W] = live_en[l] ? rbyte[l] : '0;
                inpack_n = !(!iord_n && (live_en != 2'b00));
            end
            default: ;
        endcase
    end

    assign is16_n = !(io_live && !reg_n && (!ce1_n || !ce2_n) && (addr[2:0] == 3'b000));

    // checks
    assert_hi_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en[1] |-> !ce2_n);
    assert_lo_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en[0] |-> !ce1_n);
    assert_io_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!iord_n && lane_en != 2'b00) |-> !reg_n);
    assert_commit_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |-> ($past(we_n) && $past(iowr_n)));
    assert_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n) |-> (lane_en == 2'b00));
    assert_is16_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !is16_n |-> (addr[2:0] == 3'b000 && !reg_n));
    assert_inpack_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> (!iord_n && !reg_n && lane_en != 2'b00));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_READ) |-> (rdata == '0 && lane_en == 2'b00));
endmodule

// File: tb/sim_cbd_decoder.sv
module sim_cbd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic        oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  lane_en;
    logic        is16_n, inpack_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] last_rd;
    logic [1:0]  last_le;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .addr(addr),
        .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .wdata(wdata), .rdata(rdata), .lane_en(lane_en), .is16_n(is16_n),
        .inpack_n(inpack_n)
    );

    // {ce1_n, ce2_n, a0, word offset[2:0], expected lane_en[1:0]}
    localparam logic [7:0] VEC [16] = '{
        8'b000_001_11, 8'b001_001_11, 8'b010_001_01, 8'b011_001_01,
        8'b100_001_10, 8'b101_001_10, 8'b110_001_00, 8'b111_001_00,
        8'b000_111_11, 8'b001_111_11, 8'b010_111_01, 8'b011_111_01,
        8'b100_111_10, 8'b101_111_10, 8'b110_111_00, 8'b111_111_00
    };

    // reference register model
    logic [7:0] m_tf  [16];
    logic [7:0] m_cfg [4];

    task automatic m_clear();
        for (int i = 0; i < 16; i++) m_tf[i] = 8'h00;
        for (int i = 0; i < 4; i++)  m_cfg[i] = 8'h00;
    endtask

    // -1 nothing, 0..15 task byte, 100..103 config byte
    function automatic int m_target(bit io, bit reg_l, logic [10:0] ba, bit word);
        if (io && reg_l) return -1;
        if (io || reg_l) begin
            case (ba[3:0])
                4'h0, 4'h8:       return 0;
                4'h9:             return 9;
                4'h1:             return word ? 9 : 1;
                4'hD:             return 1;
                4'hA, 4'hB, 4'hC: return -1;
                default:          return int'(ba[3:0]);
            endcase
        end
        if (ba[0]) return -1;
        if (ba[10:3] == 8'h40) return 100 + int'(ba[2:1]);
        return -1;
    endfunction

    function automatic logic [7:0] m_rd(int t);
        if (t < 0)    return 8'h00;
        if (t >= 100) return m_cfg[t-100];
        return m_tf[t];
    endfunction

    task automatic model_cycle(input bit wr, io, reg_l, c1, c2, input logic [10:0] a,
                               input logic [15:0] wd, output logic [15:0] er,
                               output logic [1:0] el);
        bit on [2];
        bit odd [2];
        bit word;
        int t [2];
        on[0] = !c1; on[1] = !c2;
        word = on[0] && on[1];
        odd[0] = c2 ? a[0] : 1'b0;
        odd[1] = 1'b1;
        er = '0; el = '0;
        for (int l = 0; l < 2; l++) begin
            t[l] = m_target(io, reg_l, {a[10:1], odd[l]}, word);
            if (on[l] && !(io && reg_l)) begin
                el[l] = 1'b1;
                er[l*8 +: 8] = m_rd(t[l]);
            end
        end
        if (wr) begin
            for (int l = 0; l < 2; l++) begin
                if (el[l] && t[l] >= 100)   m_cfg[t[l]-100] = wd[l*8 +: 8];
                else if (el[l] && t[l] >= 0) m_tf[t[l]] = wd[l*8 +: 8];
            end
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, io, reg_l, c1, c2, input logic [10:0] a,
                       input logic [15:0] wd, output logic inp, output logic i16);
        @(negedge clk);
        ce1_n = c1; ce2_n = c2; addr = a; reg_n = reg_l; wdata = wd;
        if (wr) begin if (io) iowr_n = 1'b0; else we_n = 1'b0; end
        else    begin if (io) iord_n = 1'b0; else oe_n = 1'b0; end
        @(posedge clk);
        @(negedge clk);
        last_rd = rdata; last_le = lane_en; inp = inpack_n; i16 = is16_n;
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic run(input bit wr, io, reg_l, c1, c2, input logic [10:0] a,
                       input logic [15:0] wd, input string req);
        logic [15:0] er;
        logic [1:0]  el;
        logic        ai, a16;
        bit          e16;
        model_cycle(wr, io, reg_l, c1, c2, a, wd, er, el);
        e16 = io && !reg_l && !(c1 && c2) && (a[2:0] == 3'b000);
        cyc(wr, io, reg_l, c1, c2, a, wd, ai, a16);
        chk(req, "is16_n", 32'(a16), 32'(!e16));
        if (!wr) begin
            chk(req, "rdata", 32'(last_rd), 32'(er));
            chk(req, "lane_en", 32'(last_le), 32'(el));
            chk(req, "inpack_n", 32'(ai), 32'(!(io && el != 2'b00)));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R11 watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10", "rdata", 32'(rdata), 32'h0);
        chk("R10", "lane_en", 32'(lane_en), 32'h0);
        chk("R10", "inpack_n", 32'(inpack_n), 32'h1);
        chk("R10", "is16_n", 32'(is16_n), 32'h1);
        rst_n = 1'b1;
        run(0, 1, 0, 0, 0, 11'h008, 16'h0, "R10");

        // R9 aliases
        run(1, 1, 0, 0, 0, 11'h008, 16'hBEEF, "R9");
        run(0, 1, 0, 0, 0, 11'h000, 16'h0, "R9");
        chk("R9", "word at 0", 32'(last_rd), 32'hBEEF);
        run(1, 1, 0, 1, 0, 11'h000, 16'hA500, "R9");
        run(0, 1, 0, 0, 1, 11'h001, 16'h0, "R9");
        chk("R9", "feature at 1", 32'(last_rd), 32'h00A5);
        run(0, 1, 0, 0, 1, 11'h00D, 16'h0, "R9");
        chk("R9", "feature at D", 32'(last_rd), 32'h00A5);
        run(1, 1, 0, 0, 1, 11'h00B, 16'h0077, "R9");
        run(0, 1, 0, 0, 1, 11'h00B, 16'h0, "R9");
        chk("R9", "reserved B", 32'(last_rd), 32'h0000);
        run(0, 1, 0, 0, 1, 11'h009, 16'h0, "R9");
        chk("R9", "data high at 9", 32'(last_rd), 32'h00BE);

        // preload plain offsets on the low lane
        for (int o = 2; o < 16; o++)
            if (o < 8 || o > 13)
                run(1, 1, 0, 0, 1, 11'(o), {8'h00, 8'(8'h30 + o)}, "R2");

        // table walk: every enable/A0 combination, read, write, read back
        for (int i = 0; i < 16; i++) begin
            logic [7:0]  v;
            logic [10:0] a;
            v = VEC[i];
            a = {7'd0, v[4:2], v[5]};
            run(0, 1, 0, v[7], v[6], a, 16'h0, "R2");
            chk("R1", "table lane_en", 32'(last_le), 32'(v[1:0]));
            run(1, 1, 0, v[7], v[6], a, {8'(8'hC0 + i), 8'(8'h50 + i)}, "R1");
            run(0, 1, 0, 0, 1, {a[10:1], 1'b0}, 16'h0, "R2");
            run(0, 1, 0, 0, 1, {a[10:1], 1'b1}, 16'h0, "R1");
        end

        // R4: last low-cycle sample is committed, later bus changes ignored
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b1; reg_n = 1'b0; addr = 11'h004; wdata = 16'h0011;
        iowr_n = 1'b0;
        @(posedge clk); @(negedge clk);
        wdata = 16'h0022;
        @(posedge clk); @(negedge clk);
        iowr_n = 1'b1; addr = 11'h006; wdata = 16'h0099;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ce1_n = 1'b1;
        m_tf[4] = 8'h22;
        run(0, 1, 0, 0, 1, 11'h004, 16'h0, "R4");
        chk("R4", "committed byte", 32'(last_rd), 32'h0022);
        run(0, 1, 0, 0, 1, 11'h006, 16'h0, "R4");

        // R5: no enable, no effect
        run(1, 1, 0, 1, 1, 11'h002, 16'hFFFF, "R5");
        run(0, 1, 0, 0, 1, 11'h002, 16'h0, "R5");
        run(0, 1, 0, 1, 1, 11'h002, 16'h0, "R5");

        // R3: common memory mirror, I/O with reg_n high
        run(0, 0, 1, 0, 1, 11'h7F2, 16'h0, "R3");
        run(1, 0, 1, 0, 1, 11'h3F4, 16'h0066, "R3");
        run(0, 1, 0, 0, 1, 11'h004, 16'h0, "R3");
        chk("R3", "mirror write", 32'(last_rd), 32'h0066);
        run(1, 1, 1, 0, 1, 11'h006, 16'h00EE, "R3");
        run(0, 1, 1, 0, 0, 11'h006, 16'h0, "R3");
        run(0, 1, 0, 0, 1, 11'h006, 16'h0, "R3");

        // R8: attribute space
        run(1, 0, 0, 0, 1, 11'h202, 16'h0047, "R8");
        run(0, 0, 0, 0, 1, 11'h202, 16'h0, "R8");
        chk("R8", "cfg 202", 32'(last_rd), 32'h0047);
        run(1, 0, 0, 0, 1, 11'h203, 16'h0055, "R8");
        run(0, 0, 0, 0, 1, 11'h203, 16'h0, "R8");
        run(0, 0, 0, 0, 1, 11'h202, 16'h0, "R8");
        run(1, 0, 0, 0, 1, 11'h208, 16'h0013, "R8");
        run(0, 0, 0, 0, 1, 11'h208, 16'h0, "R8");
        run(1, 0, 0, 0, 0, 11'h206, 16'h1233, "R8");
        run(0, 0, 0, 0, 0, 11'h206, 16'h0, "R8");
        chk("R8", "cfg 206 word", 32'(last_rd), 32'h0033);

        // R6 / R7
        run(0, 1, 0, 0, 0, 11'h000, 16'h0, "R6");
        run(0, 1, 0, 0, 1, 11'h002, 16'h0, "R6");
        run(0, 0, 1, 0, 0, 11'h000, 16'h0, "R6");
        run(0, 1, 0, 1, 1, 11'h004, 16'h0, "R7");
        run(0, 0, 1, 0, 1, 11'h004, 16'h0, "R7");

        // R10: reset mid-run clears the file
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
        run(0, 1, 0, 0, 0, 11'h008, 16'h0, "R10");
        chk("R10", "cleared word", 32'(last_rd), 32'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule